// File: doc/BRIEF.md
# Two-Layer Mesh Route Computation

This block picks the productive output port for a flit at one router of a network built from two identical 8x8 mesh layers stacked on each other. Every router on the rim of a layer uses its otherwise spare mesh port as a vertical link to the router at the same X and Y in the other layer. Interior routers have no vertical link.

The block is purely combinational. It takes the current router's node identifier and the destination node identifier from the flit header, and it returns a one-hot port vector. Flits that stay in their layer follow dimension-order routing. For a flit that must change layer, each planar direction is scored by the length of the shortest complete path that takes one step that way, reaches a rim router, crosses the vertical link and then travels in the destination layer. The lowest score wins. A rim router sends a cross-layer flit straight up or down. Arbitration, deflection and link timing belong to the surrounding router.

Top module: `rte_route_top`

## Requirements
- R1: `port_o` is always exactly one-hot. Bit 0 selects east (+X), bit 1 west (−X), bit 2 north (+Y), bit 3 south (−Y), bit 4 the vertical link and bit 5 local ejection.
- R2: A node identifier is 7 bits wide: bit 6 is the layer, bits 5:3 are X and bits 2:0 are Y, each X and Y in the range 0 to 7.
- R3: If the layers match and the X coordinates differ, east is selected when the destination X is larger and west when it is smaller, whatever the Y coordinates are.
- R4: If the layers match and the X coordinates are equal, north is selected when the destination Y is larger and south when it is smaller.
- R5: Local is selected exactly when layer, X and Y all match. A cross-layer flit is never ejected locally.
- R6: A cross-layer flit at a rim router (X or Y equal to 0 or 7) selects the vertical port. The vertical port is never selected at an interior router, and never for a flit that stays in its layer.
- R7: A cross-layer flit at an interior router takes the planar direction with the smallest score. A direction's score is 1 for the step to the neighbour n, plus the minimum over all rim routers p of the Manhattan distance from n to p, plus 1 for the vertical hop, plus the Manhattan distance from p to the destination coordinates.
- R8: When planar scores are equal, the priority is east first, then west, then north, then south.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_node_i | input | 7 | Identifier of this router: layer, X, Y |
| dst_node_i | input | 7 | Destination identifier from the flit header |
| port_o | output | 6 | One-hot productive output port |

## Verification
At a rim router with a cross-layer flit, the vertical candidate and the best planar direction can both give the minimum total path length at once. The vertical port has to win that tie. Among the four planar candidates at interior routers, two or more directions can share the minimum score, and the fixed east-west-north-south order must decide. Both collisions are provoked by sweeping every pair of current and destination identifiers, plus directed cases such as (2,2) to (2,2) across layers and (5,5) to (5,5) across layers. The result is judged against a bench model that finds each score by enumerating every rim router, not by using a closed form.

// File: rtl/rte_pkg.sv
package rte_pkg;
  localparam int unsigned MESH_DIM = 8;
  localparam int unsigned CW       = $clog2(MESH_DIM);
  localparam int unsigned NODE_W   = 2 * CW + 1;
  localparam int unsigned COST_W   = CW + 3;
  localparam int unsigned NDIR     = 4;
  localparam int unsigned NPORT    = 6;
  localparam logic [CW-1:0] HI     = CW'(MESH_DIM - 1);

  typedef enum int unsigned {
    P_EAST  = 0,
    P_WEST  = 1,
    P_NORTH = 2,
    P_SOUTH = 3,
    P_VERT  = 4,
    P_LOCAL = 5
  } port_e;

  typedef struct packed {
    logic          layer;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } node_t;

  function automatic logic [COST_W-1:0] absdiff(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? (COST_W'(a) - COST_W'(b)) : (COST_W'(b) - COST_W'(a));
  endfunction

  function automatic logic [COST_W-1:0] min2(input logic [COST_W-1:0] a, input logic [COST_W-1:0] b);
    return (b < a) ? b : a;
  endfunction
endpackage

// File: rtl/rte_xy.sv
module rte_xy
  import rte_pkg::*;
(
  input  logic [CW-1:0]    cur_x_i,
  input  logic [CW-1:0]    cur_y_i,
  input  logic [CW-1:0]    dst_x_i,
  input  logic [CW-1:0]    dst_y_i,
  output logic [NPORT-1:0] port_o
);
  // dimension order: X resolved before Y
  always_comb begin
    port_o = '0;
    if (dst_x_i > cur_x_i)      port_o[int'(P_EAST)]  = 1'b1;
    else if (dst_x_i < cur_x_i) port_o[int'(P_WEST)]  = 1'b1;
    else if (dst_y_i > cur_y_i) port_o[int'(P_NORTH)] = 1'b1;
    else if (dst_y_i < cur_y_i) port_o[int'(P_SOUTH)] = 1'b1;
    else                        port_o[int'(P_LOCAL)] = 1'b1;
  end
endmodule

// File: rtl/rte_edge_cost.sv
module rte_edge_cost
  import rte_pkg::*;
(
  input  logic              valid_i,
  input  logic [CW-1:0]     nb_x_i,
  input  logic [CW-1:0]     nb_y_i,
  input  logic [CW-1:0]     dst_x_i,
  input  logic [CW-1:0]     dst_y_i,
  output logic [COST_W-1:0] cost_o
);
  logic [COST_W-1:0] dx_abs, dy_abs;
  logic [COST_W-1:0] via_w, via_e, via_s, via_n, via_min;

  assign dx_abs = absdiff(nb_x_i, dst_x_i);
  assign dy_abs = absdiff(nb_y_i, dst_y_i);

  // best rim crossing on each edge: the free coordinate costs only its plain distance
  assign via_w = COST_W'(nb_x_i) + COST_W'(dst_x_i) + dy_abs;
  assign via_e = COST_W'(HI - nb_x_i) + COST_W'(HI - dst_x_i) + dy_abs;
  assign via_s = COST_W'(nb_y_i) + COST_W'(dst_y_i) + dx_abs;
  assign via_n = COST_W'(HI - nb_y_i) + COST_W'(HI - dst_y_i) + dx_abs;

  assign via_min = min2(min2(via_w, via_e), min2(via_s, via_n));

  // step to neighbour plus vertical hop
  assign cost_o = valid_i ? (via_min + COST_W'(2)) : '1;
endmodule

// File: rtl/rte_pick.sv
module rte_pick
  import rte_pkg::*;
(
  input  logic [COST_W-1:0] dir_cost_i [NDIR],
  input  logic              vert_ok_i,
  input  logic [COST_W-1:0] vert_cost_i,
  output logic [NPORT-1:0]  port_o
);
  logic [1:0] best;

  always_comb begin
    best = 2'd0;
    // strict compare keeps the earlier direction on equal scores
    for (int d = 1; d < int'(NDIR); d++) begin
      if (dir_cost_i[d] < dir_cost_i[best]) best = 2'(d);
    end
    port_o = '0;
    if (vert_ok_i && (vert_cost_i <= dir_cost_i[best])) port_o[int'(P_VERT)] = 1'b1;
    else                                                port_o[best]         = 1'b1;
  end
endmodule

// File: rtl/rte_route_top.sv
module rte_route_top
  import rte_pkg::*;
(
  input  logic [NODE_W-1:0] cur_node_i,
  input  logic [NODE_W-1:0] dst_node_i,
  output logic [NPORT-1:0]  port_o
);
  node_t cur, dst;
  logic  same_layer, on_rim;
  logic  [NPORT-1:0]  xy_port, cross_port;
  logic  [COST_W-1:0] dir_cost [NDIR];
  logic  [COST_W-1:0] vert_cost;

  assign cur        = node_t'(cur_node_i);
  assign dst        = node_t'(dst_node_i);
  assign same_layer = (cur.layer == dst.layer);
  assign on_rim     = (cur.x == '0) || (cur.x == HI) || (cur.y == '0) || (cur.y == HI);
  assign vert_cost  = COST_W'(1) + absdiff(cur.x, dst.x) + absdiff(cur.y, dst.y);

  rte_xy u_xy (
    .cur_x_i (cur.x),
    .cur_y_i (cur.y),
    .dst_x_i (dst.x),
    .dst_y_i (dst.y),
    .port_o  (xy_port)
  );

  for (genvar d = 0; d < int'(NDIR); d++) begin : g_dir
    logic          nb_ok;
    logic [CW-1:0] nb_x, nb_y;
    if (d == int'(P_EAST)) begin : g_e
      assign nb_ok = (cur.x != HI);
      assign nb_x  = cur.x + 1'b1;
      assign nb_y  = cur.y;
    end else if (d == int'(P_WEST)) begin : g_w
      assign nb_ok = (cur.x != '0);
      assign nb_x  = cur.x - 1'b1;
      assign nb_y  = cur.y;
    end else if (d == int'(P_NORTH)) begin : g_n
      assign nb_ok = (cur.y != HI);
      assign nb_x  = cur.x;
      assign nb_y  = cur.y + 1'b1;
    end else begin : g_s
      assign nb_ok = (cur.y != '0);
      assign nb_x  = cur.x;
      assign nb_y  = cur.y - 1'b1;
    end

    rte_edge_cost u_cost (
      .valid_i (nb_ok),
      .nb_x_i  (nb_x),
      .nb_y_i  (nb_y),
      .dst_x_i (dst.x),
      .dst_y_i (dst.y),
      .cost_o  (dir_cost[d])
    );
  end

  rte_pick u_pick (
    .dir_cost_i  (dir_cost),
    .vert_ok_i   (on_rim),
    .vert_cost_i (vert_cost),
    .port_o      (cross_port)
  );

  assign port_o = same_layer ? xy_port : cross_port;

  always_comb begin
    if (!$isunknown({cur_node_i, dst_node_i})) begin
      AST_ONE_HOT: assert ($onehot(port_o)) else $error("port not one-hot"); // R1
      AST_X_FIRST: assert (!(same_layer && (cur.x != dst.x)) || (port_o[5:2] == '0))
        else $error("Y or non-planar port while X unresolved"); // R3
      AST_LOCAL_HOME: assert (port_o[int'(P_LOCAL)] == (cur_node_i == dst_node_i))
        else $error("local port mismatch"); // R5
      AST_RIM_VERT: assert (!(!same_layer && on_rim) || port_o[int'(P_VERT)])
        else $error("rim cross-layer flit not sent vertical"); // R6
      AST_VERT_LEGAL: assert (!port_o[int'(P_VERT)] || (!same_layer && on_rim))
        else $error("illegal vertical selection"); // R6
      AST_INNER_PLANAR: assert (!(!same_layer && !on_rim) || (port_o[3:0] != '0))
        else $error("interior cross-layer flit not planar"); // R7
    end
  end
endmodule

// File: tb/sim_rte_route_top.sv
module sim_rte_route_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int N_RAND     = 2000;

  logic       clk = 1'b0;
  logic [6:0] cur_node, dst_node;
  logic [5:0] port;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  rte_route_top u0 (
    .cur_node_i (cur_node),
    .dst_node_i (dst_node),
    .port_o     (port)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int man(input int ax, input int ay, input int bx, input int by);
    return ((ax > bx) ? ax - bx : bx - ax) + ((ay > by) ? ay - by : by - ay);
  endfunction

  function automatic bit rim(input int x, input int y);
    return (x == 0) || (x == 7) || (y == 0) || (y == 7);
  endfunction

  // score through every rim router, enumerated
  function automatic int dir_score(input int nx, input int ny, input int dx, input int dy);
    int best = 1000;
    if (nx < 0 || nx > 7 || ny < 0 || ny > 7) return 1000;
    for (int px = 0; px < 8; px++)
      for (int py = 0; py < 8; py++)
        if (rim(px, py) && (man(nx, ny, px, py) + 1 + man(px, py, dx, dy) < best))
          best = man(nx, ny, px, py) + 1 + man(px, py, dx, dy);
    return 1 + best;
  endfunction

  function automatic logic [5:0] ref_port(input logic [6:0] c, input logic [6:0] d);
    int cx = int'(c[5:3]), cy = int'(c[2:0]);
    int dx = int'(d[5:3]), dy = int'(d[2:0]);
    int sc [4];
    int best_cost;
    int best_idx;
    if (c[6] == d[6]) begin
      if (dx > cx) return 6'b000001;
      if (dx < cx) return 6'b000010;
      if (dy > cy) return 6'b000100;
      if (dy < cy) return 6'b001000;
      return 6'b100000;
    end
    sc[0] = dir_score(cx + 1, cy, dx, dy);
    sc[1] = dir_score(cx - 1, cy, dx, dy);
    sc[2] = dir_score(cx, cy + 1, dx, dy);
    sc[3] = dir_score(cx, cy - 1, dx, dy);
    best_cost = rim(cx, cy) ? 1 + man(cx, cy, dx, dy) : 2000;
    best_idx  = 4;
    for (int k = 0; k < 4; k++)
      if (sc[k] < best_cost || (best_idx == 4 && !rim(cx, cy) && k == 0)) begin
        best_cost = sc[k];
        best_idx  = k;
      end
    return 6'(1 << best_idx);
  endfunction

  function automatic string req_of(input logic [6:0] c, input logic [6:0] d);
    if (c[6] == d[6]) begin
      if (c[5:3] != d[5:3]) return "R3";
      if (c[2:0] != d[2:0]) return "R4";
      return "R5";
    end
    if (rim(int'(c[5:3]), int'(c[2:0]))) return "R6";
    return "R7";
  endfunction

  task automatic check(input logic [6:0] c, input logic [6:0] d, input logic [5:0] exp, input string tag);
    cur_node = c;
    dst_node = d;
    #(CLK_PERIOD / 2);
    checks++;
    if (port !== exp) begin
      errors++;
      $display("FAIL %s cur=%h dst=%h actual=%b expected=%b", tag, c, d, port, exp);
    end
    checks++;
    if ($countones(port) != 1) begin
      errors++;
      $display("FAIL R1 cur=%h dst=%h actual=%b expected=one-hot", c, d, port);
    end
    #(CLK_PERIOD / 2);
  endtask

  function automatic logic [6:0] nd(input int l, input int x, input int y);
    return {1'(l), 3'(x), 3'(y)};
  endfunction

  initial begin
    cur_node = '0;
    dst_node = '0;
    @(negedge clk);
    // idle identity: home node ejects locally
    check(nd(0, 0, 0), nd(0, 0, 0), 6'b100000, "R5");
    // R2 field order: layer bit6, X bits5:3, Y bits2:0
    check(7'b0_001_010, 7'b0_110_010, 6'b000001, "R2");
    check(7'b1_011_110, 7'b1_011_001, 6'b001000, "R2");
    // R3 X before Y
    check(nd(0, 2, 2), nd(0, 6, 7), 6'b000001, "R3");
    check(nd(1, 5, 0), nd(1, 1, 7), 6'b000010, "R3");
    // R4
    check(nd(0, 4, 1), nd(0, 4, 6), 6'b000100, "R4");
    // R5 cross-layer same coords never local
    check(nd(0, 3, 3), nd(1, 3, 3), 6'b000010, "R5");
    // R6 rim corner and edge go vertical
    check(nd(0, 7, 7), nd(1, 0, 0), 6'b010000, "R6");
    check(nd(1, 0, 4), nd(0, 5, 4), 6'b010000, "R6");
    // R7 interior: west is strictly best
    check(nd(0, 2, 4), nd(1, 2, 4), 6'b000010, "R7");
    // R8 ties: west beats south, east beats north
    check(nd(0, 2, 2), nd(1, 2, 2), 6'b000010, "R8");
    check(nd(0, 5, 5), nd(1, 5, 5), 6'b000001, "R8");
    // exhaustive sweep
    for (int c = 0; c < 128; c++)
      for (int d = 0; d < 128; d++)
        check(7'(c), 7'(d), ref_port(7'(c), 7'(d)), req_of(7'(c), 7'(d)));
    // seeded random replay
    void'($urandom(32'd20417));
    for (int i = 0; i < N_RAND; i++) begin
      logic [6:0] rc, rd;
      rc = 7'($urandom);
      rd = 7'($urandom);
      check(rc, rd, ref_port(rc, rd), req_of(rc, rd));
    end
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule